// File: doc/BRIEF.md
# FIFO Threshold Offset Register Loader

This block keeps the two threshold offsets that a FIFO's flag logic compares against, one for the almost-empty flag and one for the almost-full flag. Software or a host loads them through the FIFO's existing 9-bit data input and reads them back through the data output path. No address bus is used. A configuration select pin, combined with the write enable or the pair of read enables, steps an internal pointer through four nibble-wide slots. The slots are taken in a fixed order, and reads follow the same order.

Each offset is built from two 4-bit slots. Only the low nibble of the data bus is used. The assembled offsets are driven out continuously to the flag comparators. Reads and writes share a single pointer, so any accepted access moves it to the next slot. After the last slot the pointer wraps back to the first.

Top module: `ofs_loader`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, both offsets equal 7, `rd_data_o` is 0, `rd_valid_o` is 0 and the pointer is at slot 0.
- R2: Writes fill the slots in this order: slot 0 is `empty_ofs_o[3:0]`, slot 1 is `empty_ofs_o[7:4]`, slot 2 is `full_ofs_o[3:0]` and slot 3 is `full_ofs_o[7:4]`. A write happens on a rising clock edge with `load_ni`=0 and `wr_en_ni`=0.
- R3: After an access to slot 3, the next access goes to slot 0.
- R4: A write stores only `data_i[3:0]`. Bits 8:4 are ignored. A readback drives `rd_data_o[8:4]` as 0.
- R5: When `load_ni`=1 and `wr_en_ni`=0, the offsets do not change and the pointer does not move.
- R6: When `load_ni`=0 and `wr_en_ni`=1, and the read enables are not both low, nothing changes.
- R7: A read happens when `load_ni`=0, `rd_en1_ni`=0, `rd_en2_ni`=0 and `wr_en_ni`=1. One cycle later, `rd_data_o` holds the current slot zero-extended, and `rd_valid_o` is high for that one cycle.
- R8: When only one read enable is low, no read happens: `rd_data_o` keeps its value and `rd_valid_o` stays 0.
- R9: A read moves the shared pointer exactly as a write does.
- R10: When a write and a read are requested in the same cycle, the write wins. No read takes place and the pointer moves once.
- R11: `empty_ofs_o` and `full_ofs_o` show the stored slots continuously, with the lower slot of each offset in bits 3:0.
- R12: When `load_ni`=1, a read request with both read enables low does not read and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Offset access select, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| rd_en1_ni | input | 1 | First read enable, active low |
| rd_en2_ni | input | 1 | Second read enable, active low |
| data_i | input | 9 | Write data; only bits 3:0 are used |
| rd_data_o | output | 9 | Registered readback of the selected slot |
| rd_valid_o | output | 1 | High for one cycle after a read |
| empty_ofs_o | output | 8 | Assembled almost-empty offset |
| full_ofs_o | output | 8 | Assembled almost-full offset |

## Verification
The bench builds the block with its defaults: a 9-bit bus, 4-bit slots, two slots per offset and a reset value of 7 for both offsets. With these values, one pass through all four slots takes four accesses, so the wrap shows up after a few cycles. The tests then mix reads and writes so that the shared pointer is seen crossing the boundary from both paths. Data words with set upper bits, single-enable reads, a write and a read in the same cycle, and a reset in the middle of the sequence bring the ignore, priority and restart cases within reach of the scoreboard.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

  // write wins over read when both are requested
  function automatic acc_e decode_acc(logic load_n, logic wr_n, logic rd1_n, logic rd2_n);
    if (load_n) return ACC_IDLE;
    if (!wr_n) return ACC_WRITE;
    if (!rd1_n && !rd2_n) return ACC_READ;
    return ACC_IDLE;
  endfunction
endpackage

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr #(
  parameter int STEPS = 4,
  localparam int PW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [PW-1:0] sel_o
);
  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  logic [PW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (adv_i) sel_q <= (sel_q == LAST) ? '0 : sel_q + 1'b1;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank #(
  parameter int SLICE_W = 4,
  parameter int SLICES = 2,
  parameter int EMPTY_DEF = 7,
  parameter int FULL_DEF = 7,
  localparam int STEPS = 2 * SLICES,
  localparam int OFS_W = SLICE_W * SLICES,
  localparam int PW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [PW-1:0]            sel_i,
  input  logic [SLICE_W-1:0]       wdata_i,
  output logic [STEPS*SLICE_W-1:0] slots_o
);
  localparam logic [OFS_W-1:0] EMPTY_V = OFS_W'(EMPTY_DEF);
  localparam logic [OFS_W-1:0] FULL_V  = OFS_W'(FULL_DEF);

  for (genvar s = 0; s < STEPS; s++) begin : g_slot
    localparam int PART = s % SLICES;
    localparam logic [OFS_W-1:0] DEF_V = (s < SLICES) ? EMPTY_V : FULL_V;
    localparam logic [SLICE_W-1:0] RST_V = DEF_V[PART*SLICE_W +: SLICE_W];

    logic [SLICE_W-1:0] slot_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= RST_V;
      else if (wr_i && (sel_i == PW'(s))) slot_q <= wdata_i;
    end

    assign slots_o[s*SLICE_W +: SLICE_W] = slot_q;
  end
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port #(
  parameter int DATA_W = 9,
  parameter int SLICE_W = 4,
  parameter int STEPS = 4,
  localparam int PW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic [PW-1:0]            sel_i,
  input  logic [STEPS*SLICE_W-1:0] slots_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_valid_o
);
  logic [SLICE_W-1:0] pick;
  logic [DATA_W-1:0]  rd_q;
  logic               vld_q;

  always_comb begin
    pick = '0;
    for (int s = 0; s < STEPS; s++)
      if (sel_i == PW'(s)) pick = slots_i[s*SLICE_W +: SLICE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) rd_q <= DATA_W'(pick);
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = vld_q;
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int SLICE_W = 4,
  parameter int SLICES = 2,
  parameter int EMPTY_DEF = 7,
  parameter int FULL_DEF = 7,
  localparam int OFS_W = SLICE_W * SLICES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              wr_en_ni,
  input  logic              rd_en1_ni,
  input  logic              rd_en2_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o
);
  localparam int STEPS = 2 * SLICES;
  localparam int PW = (STEPS > 1) ? $clog2(STEPS) : 1;

  acc_e                     acc;
  logic                     wr, rd;
  logic [PW-1:0]            sel;
  logic [STEPS*SLICE_W-1:0] slots;

  assign acc = decode_acc(load_ni, wr_en_ni, rd_en1_ni, rd_en2_ni);
  assign wr  = (acc == ACC_WRITE);
  assign rd  = (acc == ACC_READ);

  ofs_seq_ptr #(.STEPS(STEPS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (wr | rd),
    .sel_o (sel)
  );

  ofs_reg_bank #(
    .SLICE_W(SLICE_W), .SLICES(SLICES),
    .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .sel_i  (sel),
    .wdata_i(data_i[SLICE_W-1:0]),
    .slots_o(slots)
  );

  ofs_rd_port #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .STEPS(STEPS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd),
    .sel_i     (sel),
    .slots_i   (slots),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );

  assign empty_ofs_o = slots[OFS_W-1:0];
  assign full_ofs_o  = slots[2*OFS_W-1:OFS_W];
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
  parameter int DATA_W = 9,
  parameter int SLICE_W = 4,
  parameter int SLICES = 2,
  localparam int OFS_W = SLICE_W * SLICES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_ni,
  input logic              wr_en_ni,
  input logic              rd_en1_ni,
  input logic              rd_en2_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic [OFS_W-1:0]  empty_ofs_o,
  input logic [OFS_W-1:0]  full_ofs_o
);
  localparam int STEPS = 2 * SLICES;

  logic               wr_acc, rd_acc;
  logic [2*OFS_W-1:0] all_ofs;
  int                 step_q, widx_q;
  logic [SLICE_W-1:0] wnib_q, rnib_q;
  logic               wr_d_q;

  assign wr_acc  = !load_ni && !wr_en_ni;
  assign rd_acc  = !load_ni && wr_en_ni && !rd_en1_ni && !rd_en2_ni;
  assign all_ofs = {full_ofs_o, empty_ofs_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 0;
      widx_q <= 0;
      wnib_q <= '0;
      rnib_q <= '0;
      wr_d_q <= 1'b0;
    end else begin
      wr_d_q <= wr_acc;
      if (wr_acc || rd_acc) step_q <= (step_q == STEPS - 1) ? 0 : step_q + 1;
      if (wr_acc) begin
        widx_q <= step_q;
        wnib_q <= data_i[SLICE_W-1:0];
      end
      if (rd_acc) rnib_q <= all_ofs[step_q*SLICE_W +: SLICE_W];
    end
  end

  assert_ofs_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_acc |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  assert_write_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d_q |-> (all_ofs[widx_q*SLICE_W +: SLICE_W] == wnib_q));

  assert_rd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rd_valid_o);

  assert_no_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> (!rd_valid_o && $stable(rd_data_o)));

  assert_rd_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o[SLICE_W-1:0] == rnib_q));

  assert_rd_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:SLICE_W] == '0);
endmodule

bind ofs_loader ofs_loader_chk #(
  .DATA_W(DATA_W), .SLICE_W(SLICE_W), .SLICES(SLICES)
) u_chk (.*);

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_ni = 1'b1, wr_en_ni = 1'b1, rd_en1_ni = 1'b1, rd_en2_ni = 1'b1;
  logic [8:0] data_i = '0;
  logic [8:0] rd_data_o;
  logic       rd_valid_o;
  logic [7:0] empty_ofs_o, full_ofs_o;

  int         n_run = 0, n_fail = 0;
  logic [3:0] exp_nib [4];
  int         exp_ptr;
  logic [8:0] exp_q [$];
  logic [8:0] last_rd;
  logic       exp_rv;
  logic       mon_on = 1'b0;
  string      cur_req = "R7";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ofs_loader u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) exp_nib[i] = (i % 2 == 0) ? 4'h7 : 4'h0;
    exp_ptr = 0;
    exp_q.delete();
    last_rd = '0;
    exp_rv = 1'b0;
  endtask

  task automatic check_ofs(string req);
    check(req, {24'd0, empty_ofs_o}, {24'd0, exp_nib[1], exp_nib[0]});
    check(req, {24'd0, full_ofs_o}, {24'd0, exp_nib[3], exp_nib[2]});
  endtask

  // driver: one cycle of stimulus, pushes expected reads
  task automatic cyc(logic l, logic w, logic r1, logic r2, logic [8:0] d, string req);
    @(negedge clk_i);
    load_ni = l; wr_en_ni = w; rd_en1_ni = r1; rd_en2_ni = r2; data_i = d;
    cur_req = req;
    @(posedge clk_i);
    exp_rv = 1'b0;
    if (!l && !w) begin
      exp_nib[exp_ptr] = d[3:0];
      exp_ptr = (exp_ptr + 1) % 4;
    end else if (!l && !r1 && !r2) begin
      exp_q.push_back({5'd0, exp_nib[exp_ptr]});
      exp_rv = 1'b1;
      exp_ptr = (exp_ptr + 1) % 4;
    end
    #1;
    load_ni = 1'b1; wr_en_ni = 1'b1; rd_en1_ni = 1'b1; rd_en2_ni = 1'b1;
    @(negedge clk_i);
    check_ofs(req);
  endtask

  // monitor: compares read results as they appear
  always @(negedge clk_i) begin
    if (mon_on && rst_ni) begin
      check({cur_req, " valid"}, {31'd0, rd_valid_o}, {31'd0, exp_rv});
      if (rd_valid_o) begin
        if (exp_q.size() == 0) check({cur_req, " queue"}, {23'd0, rd_data_o}, 32'hFFFF_FFFF);
        else begin
          check(cur_req, {23'd0, rd_data_o}, {23'd0, exp_q.pop_front()});
          last_rd = rd_data_o;
        end
      end else check({cur_req, " hold"}, {23'd0, rd_data_o}, {23'd0, last_rd});
      exp_rv = 1'b0;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 3);
    // R1: values held during reset
    check("R1", {24'd0, empty_ofs_o}, 32'h07);
    check("R1", {24'd0, full_ofs_o}, 32'h07);
    check("R1", {23'd0, rd_data_o}, 32'h0);
    check("R1", {31'd0, rd_valid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    // R7 R9: read all four slots in order after reset
    cyc(0, 1, 0, 0, 9'h000, "R7");
    cyc(0, 1, 0, 0, 9'h000, "R9");
    cyc(0, 1, 0, 0, 9'h000, "R9");
    cyc(0, 1, 0, 0, 9'h000, "R9");
    // R2 R4 R11: write ordering, upper data bits ignored
    cyc(0, 0, 1, 1, 9'h1A5, "R4");
    cyc(0, 0, 1, 1, 9'h0C3, "R2");
    cyc(0, 0, 1, 1, 9'h002, "R2");
    cyc(0, 0, 1, 1, 9'h1FF, "R11");
    check("R11", {16'd0, full_ofs_o, empty_ofs_o}, 32'hF235);
    // R6: load low, write enable high
    cyc(0, 1, 1, 1, 9'h00E, "R6");
    // R3: wrap to slot 0
    cyc(0, 0, 1, 1, 9'h009, "R3");
    // R5: normal FIFO write leaves offsets and pointer
    cyc(1, 0, 1, 1, 9'h00D, "R5");
    cyc(0, 0, 1, 1, 9'h006, "R5");
    check("R5", {24'd0, empty_ofs_o}, 32'h69);
    // R8: single read enable; R12: read with load high
    cyc(0, 1, 0, 1, 9'h000, "R8");
    cyc(0, 1, 1, 0, 9'h000, "R8");
    cyc(1, 1, 0, 0, 9'h000, "R12");
    // R9 R3: reads continue from slot 2 and wrap
    cyc(0, 1, 0, 0, 9'h000, "R9");
    cyc(0, 1, 0, 0, 9'h000, "R9");
    cyc(0, 1, 0, 0, 9'h000, "R3");
    // R10: write and read together, write wins
    cyc(0, 0, 0, 0, 9'h004, "R10");
    check("R10", {24'd0, empty_ofs_o}, 32'h49);
    cyc(0, 1, 0, 0, 9'h000, "R10");
    // R1: reset mid-run restores defaults and pointer
    @(negedge clk_i);
    mon_on = 1'b0;
    rst_ni = 1'b0;
    model_reset();
    #(CLK_PERIOD / 4);
    check("R1", {16'd0, full_ofs_o, empty_ofs_o}, 32'h0707);
    check("R1", {31'd0, rd_valid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    cyc(0, 0, 1, 1, 9'h001, "R1");
    check("R1", {24'd0, empty_ofs_o}, 32'h01);
    cyc(0, 1, 0, 0, 9'h000, "R1");
    @(negedge clk_i);
    check("R7", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule